// File: doc/BRIEF.md
# I2C Control Register with Self-Clearing Commands

This block holds the six control bits of an I2C master/slave interface behind a plain CPU write/read port, and applies the hardware set and clear rules for them. The bits are the interface enable, the general-call enable, the start request, the acknowledge enable, the stop request and the interrupt enable. A separate bus engine moves SDA and SCL. It reports start-sent, stop-sent, byte-finished and master/slave status back to this block. In return, the block gives the engine one-cycle command strobes, level enables, an SCL hold request, a slave-release request and a clear hook for the status flags.

Turning the interface on takes two writes. A write made while the interface is off can only set the enable bit. The other control bits are loaded only by a later write made while the interface is on. Clearing the enable wipes every control bit except the stop request. It also keeps the status flags cleared and the bus released. The start request clears itself once the engine reports the start condition. The stop request clears itself in master mode when the stop has gone out. In slave mode the stop request is a release command that software must withdraw itself.

Top module: `i2c_ctl_reg`

## Requirements
- R1: After reset `rd_data_o` reads 00h. Bits 7 and 6 of `rd_data_o` always read 0. The read layout is bit5 enable, bit4 general-call enable, bit3 start, bit2 ack, bit1 stop, bit0 interrupt enable.
- R2: A write while the enable is 0 changes only the enable, which takes `wr_data_i[5]`. All other bits keep their values, so writing FFh from the off state reads back 20h.
- R3: A write while the enable is 1 and `wr_data_i[5]`=1 loads bits 5..0 as written. `gc_en_o`, `ack_en_o` and `irq_en_o` then follow bits 4, 2 and 0.
- R4: While the enable is 0, the general-call, start, ack and interrupt-enable bits are 0. `idle_clr_o` is 1 while the enable is 0. A write with `wr_data_i[5]`=0 loads the stop bit from `wr_data_i[1]`. Disabling never clears the stop bit by itself.
- R5: `start_sent_i` clears the start bit at the next edge. `start_irq_o` is high in the same cycle as `start_sent_i` when both the start bit and the interrupt-enable bit are 1.
- R6: A 0-to-1 change of the start bit gives a one-cycle `start_pulse_o` in the cycle after the write. `start_rep_o` marks the same pulse as a repeated start when `master_i`=1.
- R7: In master mode (`master_i`=1), a rising stop bit gives a one-cycle `stop_pulse_o`, and `stop_sent_i` clears the stop bit.
- R8: In slave mode (`master_i`=0), `stop_sent_i` does not clear the stop bit and no `stop_pulse_o` occurs. A `btf_i` pulse while the stop bit is 1 raises `slave_release_o` from the next cycle. It stays raised until software clears the stop bit.
- R9: `gc_ack_o` is 1 only when the enable and general-call bits are 1, `addr_valid_i`=1 and `addr_i`=00h. Address 01h never produces it.
- R10: `scl_hold_o` is 1 when the enable is 1 and any bit of `hold_src_i` is 1. The bits of `hold_src_i` are: [0] 10-bit header, [1] start sent, [2] byte finished, [3] addressed as slave, [4] address-match event. It is 0 while the enable is 0.
- R11: When a software write and a hardware clear of the start bit land in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU write strobe |
| wr_data_i | input | 8 | CPU write data |
| rd_data_o | output | 8 | Register read value |
| master_i | input | 1 | Engine is in master mode |
| start_sent_i | input | 1 | Engine has sent the start condition |
| stop_sent_i | input | 1 | Engine has sent the stop condition |
| btf_i | input | 1 | Byte transfer finished |
| hold_src_i | input | 5 | Pending flags that stretch SCL |
| addr_valid_i | input | 1 | Received address byte is valid |
| addr_i | input | 8 | Received address byte |
| enable_o | output | 1 | Interface enabled |
| gc_en_o | output | 1 | General call enabled |
| ack_en_o | output | 1 | Acknowledge enabled |
| irq_en_o | output | 1 | Interrupt enabled |
| start_pulse_o | output | 1 | One-cycle start command |
| start_rep_o | output | 1 | Start command is a repeated start |
| stop_pulse_o | output | 1 | One-cycle master stop command |
| slave_release_o | output | 1 | Slave releases SCL and SDA |
| start_irq_o | output | 1 | Start-sent interrupt |
| scl_hold_o | output | 1 | Hold SCL low |
| idle_clr_o | output | 1 | Clear status flags and release bus |
| gc_ack_o | output | 1 | Acknowledge general-call address |

## Verification
The hardest state to reach is a stop request that survives a disable. Getting there takes a fully enabled interface that is then written with the enable clear and the stop bit set. After that, a write from the off state must leave the stop bit untouched, and a later re-enable must find it still there. The vector table walks that exact write order. Directed steps then put a software write and a start-sent event in the same cycle, and take the slave release through byte-finished, stop-sent and a software clear.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int REG_W    = 8;
  localparam int PE_BIT   = 5;
  localparam int ENGC_BIT = 4;
  localparam int START_BIT = 3;
  localparam int ACK_BIT  = 2;
  localparam int STOP_BIT = 1;
  localparam int ITE_BIT  = 0;

  typedef struct packed {
    logic pe;
    logic engc;
    logic start;
    logic ack;
    logic stop;
    logic ite;
  } ctl_bits_t;
endpackage

// File: rtl/i2c_ctl_core.sv
module i2c_ctl_core
  import i2c_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             start_sent_i,
  input  logic             stop_sent_i,
  input  logic             master_i,
  output ctl_bits_t        ctl_o
);
  ctl_bits_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (start_sent_i)            ctl_d.start = 1'b0;
    if (stop_sent_i && master_i) ctl_d.stop  = 1'b0;
    if (wr_en_i) begin
      if (!ctl_q.pe) begin
        // off state: first write only arms the enable
        ctl_d.pe = wr_data_i[PE_BIT];
      end else if (!wr_data_i[PE_BIT]) begin
        ctl_d      = '0;
        ctl_d.stop = wr_data_i[STOP_BIT];
      end else begin
        ctl_d.pe    = 1'b1;
        ctl_d.engc  = wr_data_i[ENGC_BIT];
        ctl_d.start = wr_data_i[START_BIT];
        ctl_d.ack   = wr_data_i[ACK_BIT];
        ctl_d.stop  = wr_data_i[STOP_BIT];
        ctl_d.ite   = wr_data_i[ITE_BIT];
      end
    end
    if (!ctl_d.pe) begin
      ctl_d.engc  = 1'b0;
      ctl_d.start = 1'b0;
      ctl_d.ack   = 1'b0;
      ctl_d.ite   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  // R4
  pe_off_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_q.pe |-> !(ctl_q.engc || ctl_q.start || ctl_q.ack || ctl_q.ite));

  // R2
  first_write_pe_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !ctl_q.pe && wr_data_i[PE_BIT])
      |=> (ctl_q.pe && !ctl_q.engc && !ctl_q.start && !ctl_q.ack && !ctl_q.ite && $stable(ctl_q.stop)));

  // R5
  start_hw_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_sent_i && !wr_en_i) |=> !ctl_q.start);

  // R8
  slave_stop_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.stop && !master_i && !wr_en_i) |=> ctl_q.stop);

  // R11
  sw_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ctl_q.pe && wr_data_i[PE_BIT] && wr_data_i[START_BIT]) |=> ctl_q.start);
endmodule

// File: rtl/i2c_ctl_strobe.sv
module i2c_ctl_strobe #(
  parameter int N_CMD = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CMD-1:0] lvl_i,
  output logic [N_CMD-1:0] pulse_o
);
  for (genvar g = 0; g < N_CMD; g++) begin : g_cmd
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i[g];
    end
    assign pulse_o[g] = lvl_i[g] & ~prev_q;

    // R6
    pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o[g] |=> !pulse_o[g]);
  end
endmodule

// File: rtl/i2c_ctl_hold.sv
module i2c_ctl_hold #(
  parameter int N_HOLD = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pe_i,
  input  logic              stop_i,
  input  logic              master_i,
  input  logic              btf_i,
  input  logic [N_HOLD-1:0] hold_src_i,
  output logic              scl_hold_o,
  output logic              slave_release_o
);
  logic btf_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 btf_seen_q <= 1'b0;
    else if (!stop_i || !pe_i)   btf_seen_q <= 1'b0;
    else if (btf_i && !master_i) btf_seen_q <= 1'b1;
  end

  assign slave_release_o = btf_seen_q & stop_i & pe_i & ~master_i;
  assign scl_hold_o      = pe_i & (|hold_src_i);

  // R8
  release_after_btf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_i && stop_i && !master_i && btf_i)
      |=> (slave_release_o || !stop_i || !pe_i || master_i));
endmodule

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
  import i2c_ctl_pkg::*;
#(
  parameter int              N_HOLD  = 5,
  parameter logic [REG_W-1:0] GC_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              master_i,
  input  logic              start_sent_i,
  input  logic              stop_sent_i,
  input  logic              btf_i,
  input  logic [N_HOLD-1:0] hold_src_i,
  input  logic              addr_valid_i,
  input  logic [REG_W-1:0]  addr_i,
  output logic              enable_o,
  output logic              gc_en_o,
  output logic              ack_en_o,
  output logic              irq_en_o,
  output logic              start_pulse_o,
  output logic              start_rep_o,
  output logic              stop_pulse_o,
  output logic              slave_release_o,
  output logic              start_irq_o,
  output logic              scl_hold_o,
  output logic              idle_clr_o,
  output logic              gc_ack_o
);
  localparam int N_CMD = 2;

  ctl_bits_t        ctl;
  logic [N_CMD-1:0] cmd_lvl, cmd_pulse;

  i2c_ctl_core i_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .start_sent_i (start_sent_i),
    .stop_sent_i  (stop_sent_i),
    .master_i     (master_i),
    .ctl_o        (ctl)
  );

  assign cmd_lvl = {ctl.stop & master_i, ctl.start};

  i2c_ctl_strobe #(.N_CMD(N_CMD)) i_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (cmd_lvl),
    .pulse_o (cmd_pulse)
  );

  i2c_ctl_hold #(.N_HOLD(N_HOLD)) i_hold (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .pe_i            (ctl.pe),
    .stop_i          (ctl.stop),
    .master_i        (master_i),
    .btf_i           (btf_i),
    .hold_src_i      (hold_src_i),
    .scl_hold_o      (scl_hold_o),
    .slave_release_o (slave_release_o)
  );

  assign rd_data_o     = {{(REG_W-6){1'b0}}, ctl};
  assign enable_o      = ctl.pe;
  assign gc_en_o       = ctl.engc;
  assign ack_en_o      = ctl.ack;
  assign irq_en_o      = ctl.ite;
  assign start_pulse_o = cmd_pulse[0];
  assign start_rep_o   = cmd_pulse[0] & master_i;
  assign stop_pulse_o  = cmd_pulse[1];
  assign start_irq_o   = start_sent_i & ctl.start & ctl.ite;
  assign idle_clr_o    = ~ctl.pe;
  assign gc_ack_o      = ctl.pe & ctl.engc & addr_valid_i & (addr_i == GC_ADDR);

  // R10
  hold_off_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_clr_o |-> !scl_hold_o);

  // R7
  stop_master_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && stop_sent_i && !wr_en_i) |=> !rd_data_o[STOP_BIT]);
endmodule

// File: tb/test_i2c_ctl_reg.sv
module test_i2c_ctl_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       master = 1'b0, start_sent = 1'b0, stop_sent = 1'b0, btf = 1'b0;
  logic [4:0] hold_src = '0;
  logic       addr_valid = 1'b0;
  logic [7:0] addr = '0;
  logic enable, gc_en, ack_en, irq_en, start_pulse, start_rep, stop_pulse;
  logic slave_release, start_irq, scl_hold, idle_clr, gc_ack;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_ctl_reg i_i2c_ctl_reg (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .master_i(master), .start_sent_i(start_sent),
    .stop_sent_i(stop_sent), .btf_i(btf), .hold_src_i(hold_src),
    .addr_valid_i(addr_valid), .addr_i(addr), .enable_o(enable),
    .gc_en_o(gc_en), .ack_en_o(ack_en), .irq_en_o(irq_en),
    .start_pulse_o(start_pulse), .start_rep_o(start_rep),
    .stop_pulse_o(stop_pulse), .slave_release_o(slave_release),
    .start_irq_o(start_irq), .scl_hold_o(scl_hold),
    .idle_clr_o(idle_clr), .gc_ack_o(gc_ack)
  );

  // {write data, expected read after the write}
  localparam logic [15:0] VEC [9] = '{
    16'hFF_20,  // R2 first write from off: only enable
    16'hFF_3F,  // R3 second write loads all, bits 7:6 read 0 (R1)
    16'h00_00,  // R4 disable wipes
    16'h22_20,  // R2 stop ignored while off
    16'h35_35,  // R3
    16'h02_02,  // R4 disable keeps written stop
    16'h00_02,  // R2 off-state write leaves stop
    16'h20_22,  // R2 re-enable, stop survives
    16'h20_20   // R3 software clears stop
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    hold_src = 5'b00010;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 reset read", rd_data, 8'h00);
    chk("R4 idle clear at reset", {7'b0, idle_clr}, 8'h01);
    chk("R10 no hold while off", {7'b0, scl_hold}, 8'h00);
    hold_src = '0;

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][15:8]);
      chk($sformatf("R2/R3/R4 vector %0d", i), rd_data, VEC[i][7:0]);
    end
    chk("R3 enables follow bits", {5'b0, gc_en, ack_en, irq_en}, 8'h00);
    wr(8'h35);
    chk("R3 enables follow bits", {5'b0, gc_en, ack_en, irq_en}, 8'h07);

    // R6 start pulse, not repeated
    wr(8'h29);
    chk("R6 start pulse", {6'b0, start_pulse, start_rep}, 8'h02);
    tick();
    chk("R6 pulse one cycle", {7'b0, start_pulse}, 8'h00);
    // R5 start-sent interrupt and clear
    start_sent = 1'b1; #0;
    chk("R5 start irq", {7'b0, start_irq}, 8'h01);
    tick(); start_sent = 1'b0;
    chk("R5 start cleared", rd_data, 8'h21);

    // R6 repeated start in master mode
    master = 1'b1;
    wr(8'h29);
    chk("R6 repeated start", {6'b0, start_pulse, start_rep}, 8'h03);
    // R11 write and clear together
    start_sent = 1'b1; wr_en = 1'b1; wr_data = 8'h29;
    tick();
    wr_en = 1'b0; start_sent = 1'b0;
    chk("R11 write wins", rd_data, 8'h29);
    start_sent = 1'b1; tick(); start_sent = 1'b0;
    chk("R5 start cleared again", rd_data, 8'h21);

    // R7 master stop
    wr(8'h22);
    chk("R7 stop pulse", {7'b0, stop_pulse}, 8'h01);
    stop_sent = 1'b1; tick(); stop_sent = 1'b0;
    chk("R7 stop hw clear", rd_data, 8'h20);

    // R8 slave stop
    master = 1'b0;
    wr(8'h22);
    chk("R8 no slave stop pulse", {6'b0, stop_pulse, slave_release}, 8'h00);
    btf = 1'b1; tick(); btf = 1'b0;
    chk("R8 release after btf", {7'b0, slave_release}, 8'h01);
    stop_sent = 1'b1; tick(); stop_sent = 1'b0;
    chk("R8 stop kept in slave", rd_data, 8'h22);
    chk("R8 release held", {7'b0, slave_release}, 8'h01);
    wr(8'h20);
    chk("R8 release drops on sw clear", {7'b0, slave_release}, 8'h00);

    // R9 general call
    wr(8'h30);
    addr_valid = 1'b1; addr = 8'h00; #1;
    chk("R9 gc 00h", {7'b0, gc_ack}, 8'h01);
    addr = 8'h01; #1;
    chk("R9 gc 01h ignored", {7'b0, gc_ack}, 8'h00);
    wr(8'h20); addr = 8'h00; #1;
    chk("R9 gc disabled", {7'b0, gc_ack}, 8'h00);
    addr_valid = 1'b0;

    // R10 hold sources
    for (int b = 0; b < 5; b++) begin
      hold_src = 5'(1 << b); #1;
      chk($sformatf("R10 hold src %0d", b), {7'b0, scl_hold}, 8'h01);
    end
    hold_src = '0; #1;
    chk("R10 no hold", {7'b0, scl_hold}, 8'h00);
    hold_src = 5'b00100;
    wr(8'h00);
    chk("R4 idle clear when off", {6'b0, idle_clr, scl_hold}, 8'h02);
    hold_src = '0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule